// File: doc/BRIEF.md
# Framebuffer Scanout Fetch Sequencer

This block reads pixel words for a display raster engine out of a linear memory window. Software places a window start address and an inclusive last-byte address into one 64-bit register with a single write. The sequencer then walks that window in read bursts of a chosen length over a request/grant read port, and stores the returned words in an internal pixel FIFO. The raster side takes words from the FIFO once a programmable fill level has been reached. Each time the window has been covered, a frame-end flag is raised and a new pass starts from the most recently written window.

A second mode fetches a fixed 32-byte palette area starting at the window start, raises a palette flag, and then stops. Three sticky flags (frame end, palette loaded, FIFO ran dry) are cleared by writing ones, and each drives its own interrupt line when enabled.

Top module: `scan_fetch`

## Requirements
- R1: After a synchronous reset, every register reads zero, `irq` is zero, and `mem_req` and `pix_valid` are low.
- R2: Register 1 holds the window: bits [31:0] are the start address and bits [63:32] the inclusive last byte. One pass fetches every 4-byte beat from start to last byte, in rising address order, and the FIFO delivers them in that order, each word equal to the data returned for its beat.
- R3: A window write is held in a shadow copy and takes effect only when the next pass starts. A pass already under way keeps the pair it began with.
- R4: Register 0 bits [4:2] choose the burst length: codes 0 to 4 give 1, 2, 4, 8 and 16 beats. A write that carries code 5, 6 or 7 leaves the stored code unchanged but still updates the other fields of register 0.
- R5: No burst reaches past the last byte of the window. The final burst of a pass is shortened to the beats that remain.
- R6: A data burst is requested only when the FIFO (32 words) has at least as many free entries as the burst length. A request that has not been granted stays up.
- R7: `pix_valid` stays low after enable until the FIFO count has reached the threshold in register 0 bits [13:8].
- R8: Status bit 0 sets after the last beat of a data pass. The next pass begins immediately if the block is still enabled.
- R9: With register 0 bit 1 set, a pass fetches 32 bytes from the window start. These beats are not placed in the FIFO. Status bit 1 is then set, and no further request is made until enable (register 0 bit 0) is cleared.
- R10: Status bit 2 sets when `pix_rdy` is high, the FIFO is empty and output has already started.
- R11: Status bits (register 2) clear only when a 1 is written to them. A flag event in the same cycle as its clear leaves the bit set.
- R12: `irq[i]` is high exactly when status bit i and enable bit i of register 3 are both set.
- R13: Clearing enable lets the burst in progress finish, and no new request is made afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 control, 1 window, 2 status, 3 interrupt enable) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 5 | Burst length in beats |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pix_rdy | input | 1 | Raster side takes a word |
| pix_valid | output | 1 | FIFO word available to the raster side |
| pix_data | output | 32 | FIFO head word |
| irq | output | 3 | Per-flag interrupt lines (frame end, palette, dry FIFO) |

## Verification
The two functions that can meet in one cycle are a flag being raised and software clearing that same flag. The bench holds `pix_rdy` high against an empty, already started FIFO, so that the dry-FIFO event repeats every cycle. It then writes a 1 to status bit 2 and reads the bit back, which must still be set. After `pix_rdy` drops, the same write must clear the bit, and a clear aimed at bit 2 must leave the frame-end bit untouched.

// File: rtl/scan_fetch_pkg.sv
package scan_fetch_pkg;

    localparam int BEAT_BYTES = 4;
    localparam int PAL_BYTES  = 32;
    localparam int LEN_W      = 5;
    localparam int THR_W      = 6;
    localparam int FLAG_N     = 3;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_WIN  = 2'd1,
        RA_STAT = 2'd2,
        RA_IEN  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [2:0]       bcode;
        logic             pal;
        logic             en;
    } ctrl_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_DATA,
        SQ_HALT
    } seq_state_e;

    function automatic logic code_ok(input logic [2:0] c);
        return c <= 3'd4;
    endfunction

    function automatic logic [LEN_W-1:0] code_beats(input logic [2:0] c);
        return LEN_W'(1) << c;
    endfunction

endpackage

// File: rtl/scan_fetch_regs.sv
module scan_fetch_regs
    import scan_fetch_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [2*ADDR_W-1:0]   reg_wdata,
    output logic [2*ADDR_W-1:0]   reg_rdata,
    input  logic                  evt_eof,
    input  logic                  evt_pal,
    input  logic                  evt_unf,
    output ctrl_t                 cfg,
    output logic [ADDR_W-1:0]     sh_base,
    output logic [ADDR_W-1:0]     sh_ceil,
    output logic [FLAG_N-1:0]     status,
    output logic [FLAG_N-1:0]     ien,
    output logic [FLAG_N-1:0]     irq
);
    localparam int RW = 2 * ADDR_W;

    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] clr_v;

    assign set_v = {evt_unf, evt_pal, evt_eof};
    assign clr_v = (reg_we && reg_addr == RA_STAT) ? reg_wdata[FLAG_N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            sh_base <= '0;
            sh_ceil <= '0;
            ien     <= '0;
            status  <= '0;
        end else begin
            status <= (status & ~clr_v) | set_v;
            if (reg_we) begin
                case (reg_addr)
                    RA_CTRL: begin
                        cfg.en  <= reg_wdata[0];
                        cfg.pal <= reg_wdata[1];
                        cfg.thr <= reg_wdata[8 +: THR_W];
                        if (code_ok(reg_wdata[4:2]))
                            cfg.bcode <= reg_wdata[4:2];
                    end
                    RA_WIN: begin
                        sh_base <= reg_wdata[ADDR_W-1:0];
                        sh_ceil <= reg_wdata[RW-1:ADDR_W];
                    end
                    RA_IEN:  ien <= reg_wdata[FLAG_N-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[0]           = cfg.en;
                reg_rdata[1]           = cfg.pal;
                reg_rdata[4:2]         = cfg.bcode;
                reg_rdata[8 +: THR_W]  = cfg.thr;
            end
            RA_WIN:  reg_rdata = {sh_ceil, sh_base};
            RA_STAT: reg_rdata[FLAG_N-1:0] = status;
            default: reg_rdata[FLAG_N-1:0] = ien;
        endcase
    end

    assign irq = status & ien;

endmodule

// File: rtl/scan_fetch_fifo.sv
module scan_fetch_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       pop,
    output logic [DATA_W-1:0]          rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PW-1:0]     wp;
    logic [PW-1:0]     rp;
    logic              do_push;
    logic              do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);

    always_ff @(posedge clk) begin
        if (do_push)
            store[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    assign rdata = store[rp];

endmodule

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq
    import scan_fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ctrl_t                cfg,
    input  logic [ADDR_W-1:0]    sh_base,
    input  logic [ADDR_W-1:0]    sh_ceil,
    input  logic [CNT_W-1:0]     fifo_count,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LEN_W-1:0]     mem_len,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    output logic                 fifo_push,
    output logic                 evt_eof,
    output logic                 evt_pal,
    output logic [LEN_W-1:0]     burst_beats,
    output logic [ADDR_W-1:0]    act_base,
    output logic [ADDR_W-1:0]    act_lim,
    output logic                 act_pal
);
    localparam int SHIFT = $clog2(BEAT_BYTES);

    seq_state_e        st;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  beats_left;
    logic [ADDR_W-1:0] rem_beats;
    logic [LEN_W-1:0]  len;
    logic [CNT_W-1:0]  free_slots;
    logic              space_ok;
    logic              beat;
    logic              last_beat;
    logic              region_end;
    logic              load_now;

    assign burst_beats = code_beats(cfg.bcode);
    assign rem_beats   = ((act_lim - ptr) >> SHIFT) + 1'b1;
    assign len         = (rem_beats < ADDR_W'(burst_beats)) ? rem_beats[LEN_W-1:0]
                                                            : burst_beats;
    assign free_slots  = CNT_W'(DEPTH) - fifo_count;
    assign space_ok    = act_pal || (free_slots >= CNT_W'(len));

    assign mem_req  = (st == SQ_ISSUE) && cfg.en && space_ok;
    assign mem_addr = ptr;
    assign mem_len  = len;

    assign beat       = (st == SQ_DATA) && mem_rvalid;
    assign last_beat  = beat && (beats_left == LEN_W'(1));
    assign region_end = last_beat && (ptr + ADDR_W'(BEAT_BYTES - 1) == act_lim);
    assign fifo_push  = beat && !act_pal;
    assign evt_eof    = region_end && !act_pal;
    assign evt_pal    = region_end && act_pal;
    assign load_now   = cfg.en && ((st == SQ_IDLE) || (region_end && !act_pal));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_base <= '0;
            act_lim  <= '0;
            act_pal  <= 1'b0;
            ptr      <= '0;
        end else if (load_now) begin
            act_base <= sh_base;
            act_pal  <= cfg.pal;
            act_lim  <= cfg.pal ? sh_base + ADDR_W'(PAL_BYTES - 1) : sh_ceil;
            ptr      <= sh_base;
        end else if (beat) begin
            ptr <= ptr + ADDR_W'(BEAT_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            beats_left <= '0;
        end else begin
            case (st)
                SQ_IDLE:
                    if (cfg.en) st <= SQ_ISSUE;
                SQ_ISSUE:
                    if (!cfg.en) begin
                        st <= SQ_IDLE;
                    end else if (mem_req && mem_gnt) begin
                        beats_left <= len;
                        st         <= SQ_DATA;
                    end
                SQ_DATA:
                    if (beat) begin
                        beats_left <= beats_left - 1'b1;
                        if (last_beat) begin
                            if (region_end && act_pal) st <= SQ_HALT;
                            else                       st <= cfg.en ? SQ_ISSUE : SQ_IDLE;
                        end
                    end
                default:
                    if (!cfg.en) st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scan_fetch.sv
module scan_fetch
    import scan_fetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [2*ADDR_W-1:0]   reg_wdata,
    output logic [2*ADDR_W-1:0]   reg_rdata,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LEN_W-1:0]      mem_len,
    input  logic                  mem_gnt,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    input  logic                  pix_rdy,
    output logic                  pix_valid,
    output logic [DATA_W-1:0]     pix_data,
    output logic [FLAG_N-1:0]     irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    ctrl_t             cfg;
    logic [ADDR_W-1:0] sh_base;
    logic [ADDR_W-1:0] sh_ceil;
    logic [FLAG_N-1:0] status;
    logic [FLAG_N-1:0] ien;
    logic [CNT_W-1:0]  fifo_count;
    logic              fifo_push;
    logic              fifo_pop;
    logic              evt_eof;
    logic              evt_pal;
    logic              evt_unf;
    logic              primed;
    logic [LEN_W-1:0]  burst_beats;
    logic [ADDR_W-1:0] act_base;
    logic [ADDR_W-1:0] act_lim;
    logic              act_pal;

    scan_fetch_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_eof(evt_eof), .evt_pal(evt_pal), .evt_unf(evt_unf),
        .cfg(cfg), .sh_base(sh_base), .sh_ceil(sh_ceil),
        .status(status), .ien(ien), .irq(irq)
    );

    scan_fetch_seq #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .cfg(cfg),
        .sh_base(sh_base), .sh_ceil(sh_ceil), .fifo_count(fifo_count),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .fifo_push(fifo_push), .evt_eof(evt_eof), .evt_pal(evt_pal),
        .burst_beats(burst_beats), .act_base(act_base), .act_lim(act_lim), .act_pal(act_pal)
    );

    scan_fetch_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(fifo_push), .wdata(mem_rdata),
        .pop(fifo_pop), .rdata(pix_data), .count(fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst || !cfg.en)
            primed <= 1'b0;
        else if (fifo_count >= CNT_W'(cfg.thr))
            primed <= 1'b1;
    end

    assign pix_valid = primed && (fifo_count != '0);
    assign fifo_pop  = pix_rdy && pix_valid;
    assign evt_unf   = primed && pix_rdy && (fifo_count == '0);

endmodule

// File: rtl/scan_fetch_chk.sv
module scan_fetch_chk
    import scan_fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                reg_we,
    input logic [1:0]          reg_addr,
    input logic [2*ADDR_W-1:0] reg_wdata,
    input logic                mem_req,
    input logic                mem_gnt,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [LEN_W-1:0]    mem_len,
    input logic                mem_rvalid,
    input logic                fifo_push,
    input logic [CNT_W-1:0]    fifo_count,
    input logic [FLAG_N-1:0]   status,
    input logic [FLAG_N-1:0]   ien,
    input logic [FLAG_N-1:0]   irq,
    input logic [LEN_W-1:0]    burst_beats,
    input logic [ADDR_W-1:0]   act_base,
    input logic [ADDR_W-1:0]   act_lim
);
    logic [FLAG_N-1:0] keep;
    logic              ctrl_wr;

    assign keep    = status & ~((reg_we && reg_addr == 2'd2) ? reg_wdata[FLAG_N-1:0] : '0);
    assign ctrl_wr = reg_we && (reg_addr == 2'd0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> fifo_count < CNT_W'(DEPTH));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt && !ctrl_wr) |=> mem_req);

    // R4
    burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_len != '0) && (mem_len <= burst_beats));

    // R5
    window_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= act_base) &&
                    (mem_addr + ADDR_W'({mem_len, 2'b00}) - 1'b1 <= act_lim));

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(keep)) == $past(keep)));

    // R8
    eof_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(mem_rvalid));

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ien == '0) |-> (irq == '0));

endmodule

bind scan_fetch scan_fetch_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_rvalid(mem_rvalid), .fifo_push(fifo_push), .fifo_count(fifo_count),
    .status(status), .ien(ien), .irq(irq), .burst_beats(burst_beats),
    .act_base(act_base), .act_lim(act_lim)
);

// File: tb/tb_scan_fetch.sv
module tb_scan_fetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_rdy = 1'b0;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic [2:0]  irq;

    int total = 0;
    int bad   = 0;
    int budget = 0;
    int nlog = 0;
    logic [31:0] log_addr [64];
    logic [4:0]  log_len  [64];
    bit done = 0;

    always #10 clk = ~clk;

    scan_fetch dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .pix_rdy(pix_rdy), .pix_valid(pix_valid), .pix_data(pix_data), .irq(irq)
    );

    // memory model: grants at a negedge, returns beats (data = byte address) on following negedges
    initial begin
        int pend;
        logic [31:0] raddr;
        pend = 0;
        raddr = '0;
        forever begin
            @(negedge clk);
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            if (rst) begin
                pend = 0;
            end else if (pend > 0) begin
                mem_rvalid = 1'b1;
                mem_rdata = raddr;
                raddr = raddr + 32'd4;
                pend = pend - 1;
            end else if (mem_req && budget > 0) begin
                mem_gnt = 1'b1;
                raddr = mem_addr;
                pend = int'(mem_len);
                budget = budget - 1;
                if (nlog < 64) begin
                    log_addr[nlog] = mem_addr;
                    log_len[nlog]  = mem_len;
                end
                nlog = nlog + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        budget = 0;
        pix_rdy = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        nlog = 0;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pop_check(input string tag, input int n, input logic [31:0] base, input int wrap);
        int miss;
        logic [31:0] first_bad;
        miss = 0;
        first_bad = '0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] exp;
            @(negedge clk);
            exp = base + 32'(4 * (i % wrap));
            if (!pix_valid || pix_data !== exp) begin
                if (miss == 0) first_bad = pix_data;
                miss++;
            end
            pix_rdy = 1'b1;
        end
        @(negedge clk);
        pix_rdy = 1'b0;
        chk(tag, {32'd0, first_bad}, 64'd0);
        chk({tag, " count"}, 64'(miss), 64'd0);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rreg(2'(a), v);
            chk("R1 register after reset", v, 64'd0);
        end
        chk("R1 irq", {61'd0, irq}, 64'd0);
        chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
        chk("R1 pix_valid", {63'd0, pix_valid}, 64'd0);
    endtask

    task automatic t_burst_code();
        logic [63:0] v;
        do_reset();
        wreg(2'd0, 64'(2 << 2));
        rreg(2'd0, v);
        chk("R4 code 2 stored", {61'd0, v[4:2]}, 64'd2);
        wreg(2'd0, 64'((6 << 2) | (5 << 8)));
        rreg(2'd0, v);
        chk("R4 code 6 rejected", {61'd0, v[4:2]}, 64'd2);
        chk("R4 threshold still written", {58'd0, v[13:8]}, 64'd5);
        wreg(2'd0, 64'(4 << 2));
        rreg(2'd0, v);
        chk("R4 code 4 stored", {61'd0, v[4:2]}, 64'd4);
    endtask

    task automatic t_frame();
        logic [63:0] v;
        logic [31:0] ea [5];
        logic [4:0]  el [5];
        ea = '{32'h1000, 32'h1020, 32'h1000, 32'h1020, 32'h1000};
        el = '{5'd8, 5'd3, 5'd8, 5'd3, 5'd8};
        do_reset();
        wreg(2'd3, 64'd1);
        wreg(2'd1, {32'h0000_102B, 32'h0000_1000});
        budget = 100;
        wreg(2'd0, 64'(1 | (3 << 2)));
        repeat (120) @(posedge clk);
        chk("R6 burst count when FIFO lacks room", 64'(nlog), 64'd5);
        for (int i = 0; i < 5; i++) begin
            chk("R5 burst address", {32'd0, log_addr[i]}, {32'd0, ea[i]});
            chk("R5 burst length", {59'd0, log_len[i]}, {59'd0, el[i]});
        end
        @(negedge clk);
        chk("R6 no request while FIFO short", {63'd0, mem_req}, 64'd0);
        rreg(2'd2, v);
        chk("R8 frame-end flag", {61'd0, v[2:0]}, 64'd1);
        chk("R12 irq0 enabled", {61'd0, irq}, 64'd1);
        pop_check("R2 pixel order", 11, 32'h1000, 11);
        budget = 0;
    endtask

    task automatic t_shadow();
        do_reset();
        wreg(2'd1, {32'h0000_300F, 32'h0000_3000});
        wreg(2'd0, 64'(1 | (2 << 2)));
        wreg(2'd1, {32'h0000_400F, 32'h0000_4000});
        budget = 3;
        repeat (60) @(posedge clk);
        chk("R3 burst count", 64'(nlog), 64'd3);
        chk("R3 current pass keeps old pair", {32'd0, log_addr[0]}, 64'h3000);
        chk("R3 next pass uses new pair", {32'd0, log_addr[1]}, 64'h4000);
        chk("R8 passes repeat", {32'd0, log_addr[2]}, 64'h4000);
    endtask

    task automatic t_thresh_flags();
        logic [63:0] v;
        do_reset();
        wreg(2'd3, 64'd1);
        wreg(2'd1, {32'h0000_500F, 32'h0000_5000});
        wreg(2'd0, 64'(1 | (2 << 2) | (8 << 8)));
        budget = 1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R7 below threshold", {63'd0, pix_valid}, 64'd0);
        budget = 1;
        repeat (30) @(posedge clk);
        @(negedge clk);
        chk("R7 threshold reached", {63'd0, pix_valid}, 64'd1);
        pop_check("R7 data after threshold", 8, 32'h5000, 4);
        @(negedge clk);
        pix_rdy = 1'b1;
        repeat (3) @(posedge clk);
        rreg(2'd2, v);
        chk("R10 dry FIFO flag", {63'd0, v[2]}, 64'd1);
        chk("R12 irq2 masked", {63'd0, irq[2]}, 64'd0);
        wreg(2'd3, 64'd7);
        @(negedge clk);
        chk("R12 irq2 unmasked", {63'd0, irq[2]}, 64'd1);
        wreg(2'd2, 64'd4);
        rreg(2'd2, v);
        chk("R11 set wins over clear", {63'd0, v[2]}, 64'd1);
        @(negedge clk);
        pix_rdy = 1'b0;
        wreg(2'd2, 64'd4);
        rreg(2'd2, v);
        chk("R11 write one clears", {63'd0, v[2]}, 64'd0);
        chk("R11 other bit kept", {63'd0, v[0]}, 64'd1);
        wreg(2'd2, 64'd1);
        rreg(2'd2, v);
        chk("R11 frame flag cleared", {63'd0, v[0]}, 64'd0);
    endtask

    task automatic t_palette();
        logic [63:0] v;
        do_reset();
        wreg(2'd3, 64'd2);
        wreg(2'd1, {32'h0000_6FFF, 32'h0000_6000});
        budget = 10;
        wreg(2'd0, 64'(1 | 2 | (2 << 2)));
        repeat (60) @(posedge clk);
        chk("R9 palette bursts", 64'(nlog), 64'd2);
        chk("R9 first palette burst", {27'd0, log_len[0], log_addr[0]}, {27'd4, 32'h6000});
        chk("R9 second palette burst", {27'd0, log_len[1], log_addr[1]}, {27'd4, 32'h6010});
        rreg(2'd2, v);
        chk("R9 palette flag only", {61'd0, v[2:0]}, 64'd2);
        chk("R9 irq1", {61'd0, irq}, 64'd2);
        chk("R9 nothing in FIFO", {63'd0, pix_valid}, 64'd0);
        chk("R9 halted", {63'd0, mem_req}, 64'd0);
        budget = 0;
    endtask

    task automatic t_disable();
        int guard;
        do_reset();
        wreg(2'd1, {32'h0000_7FFF, 32'h0000_7000});
        budget = 10;
        wreg(2'd0, 64'(1 | (4 << 2)));
        guard = 0;
        while (nlog < 1 && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        wreg(2'd0, 64'(4 << 2));
        repeat (60) @(posedge clk);
        chk("R13 no new burst after disable", 64'(nlog), 64'd1);
        @(negedge clk);
        chk("R13 request low", {63'd0, mem_req}, 64'd0);
        budget = 0;
        wreg(2'd0, 64'(1 | (4 << 2)));
        repeat (3) @(posedge clk);
        pop_check("R13 burst finished", 16, 32'h7000, 16);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst_code();
        t_frame();
        t_shadow();
        t_thresh_flags();
        t_palette();
        t_disable();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule